// File: doc/BRIEF.md
# Flash Write Latch and Command Unit

This block sits in front of an on-chip flash array and gathers a page of program data in a write-only latch before the array is programmed. Bus writes anywhere in the flash address window land in the latch. Only the low eight byte-address bits pick the word, so the latch appears again and again across the whole window. A write completes after a number of cycles set by the flash wait-state setting. Writes narrower than a full word are rejected, and so are writes marked protected by the memory protection logic.

A command port takes an 8-bit operation code with a page field. The supported operations are:

- page programming, with or without locking the page afterwards;
- setting and clearing lock bits;
- setting and clearing general-purpose non-volatile bits;
- setting the security bit;
- a full erase.

Each accepted operation keeps the unit busy for a fixed number of cycles. During a programming operation the latch contents stream out to the array on a word-write port, and the latch is cleared when the operation ends. Status outputs report busy, ready, the lock, non-volatile and security state, and sticky error flags.

Top module: `flash_wlatch_unit`

## Requirements
- R1: The latch word is chosen by byte-address bits [7:2] only. Writes whose addresses differ only above bit 7 or in bits [1:0] hit the same word.
- R2: A write whose byte strobes are not all four set (4'hF) leaves the latch unchanged and sets `st_size_err`. It never starts a wait period, so `bus_wr_ready` stays 1.
- R3: A full-word write with `bus_prot` high leaves the latch unchanged and sets `st_prot_err`.
- R4: An accepted write raises `bus_wr_done` in the Nth cycle after the accepting edge. N is `fws`+1 for `fws` 0 to 2, and N is 3 for `fws` 3. `bus_wr_ready` is 0 from the accepting edge until the edge that ends the done cycle.
- R5: Code 0x01 programs the page. From the first busy cycle, `prog_we` streams latch words 0 to 63 in index order, one word per cycle, with their data. When the operation ends, every latch word reads zero.
- R6: `st_ready` is 1 after reset. An accepted command sets `st_busy` for exactly BUSY_CYCLES cycles and clears `st_ready`. `st_ready` returns to 1 in the cycle `st_busy` falls.
- R7: Code 0x02 sets and code 0x04 clears `st_lock[cmd_page]` at the end of the busy period.
- R8: Code 0x03 programs the page as in R5 and also sets `st_lock[cmd_page]`.
- R9: Code 0x0B sets and code 0x0D clears `st_nvm[cmd_page mod NVM_BITS]`. Code 0x0F sets `st_secure`.
- R10: Code 0x08 runs the busy period without emitting program words and leaves the lock, non-volatile and security state unchanged.
- R11: Any other code sets `st_cmd_err` and starts nothing: `st_busy` stays 0.
- R12: While busy, a command or a latch write is ignored and sets `st_busy_err`. A command that arrives while a latch write is pending is also ignored and sets `st_busy_err`.
- R13: All error flags are 0 after reset. Once set, an error flag holds until a command is accepted, which clears all of the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fws | input | FWS_W | Flash read wait-state setting |
| bus_wr_valid | input | 1 | Write request into the flash window |
| bus_addr | input | ADDR_W | Byte address of the write |
| bus_wdata | input | DATA_W | Write data |
| bus_strb | input | DATA_W/8 | Byte strobes |
| bus_prot | input | 1 | Protection verdict for this write |
| bus_wr_ready | output | 1 | No latch write is pending |
| bus_wr_done | output | 1 | Pending write finishes in this cycle |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Operation code |
| cmd_page | input | log2(NUM_PAGES) | Page or bit index for the operation |
| st_busy | output | 1 | Operation in progress |
| st_ready | output | 1 | Last operation finished |
| st_cmd_err | output | 1 | Unknown code seen |
| st_size_err | output | 1 | Narrow write rejected |
| st_prot_err | output | 1 | Protected write rejected |
| st_busy_err | output | 1 | Request refused while busy |
| st_lock | output | NUM_PAGES | Lock bit per page |
| st_nvm | output | NVM_BITS | General-purpose non-volatile bits |
| st_secure | output | 1 | Security bit |
| prog_we | output | 1 | Program word strobe to the array |
| prog_idx | output | LOW_BITS-2 | Word index being programmed |
| prog_data | output | DATA_W | Word data being programmed |

## Verification
The bench builds the unit with eight pages, two non-volatile bits and a 70-cycle busy period, and keeps the default 8-bit latch decode and 2-bit wait-state field. This makes every wait-state value reachable, including the capped value 3. Each programming operation streams the full 64-word latch and still leaves idle busy cycles after the stream, so a command can be issued on top of a running operation. The short busy period keeps about a dozen operations within the run. Distinct lock indices, and a non-volatile index folded from a page number, expose any mix-up between the page field and the bit it selects.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

   typedef enum logic [7:0] {
      OP_WRITE_PAGE = 8'h01,
      OP_SET_LOCK   = 8'h02,
      OP_WRITE_LOCK = 8'h03,
      OP_CLR_LOCK   = 8'h04,
      OP_ERASE_ALL  = 8'h08,
      OP_SET_NVM    = 8'h0B,
      OP_CLR_NVM    = 8'h0D,
      OP_SET_SEC    = 8'h0F
   } fwl_op_e;

   function automatic logic op_known(input logic [7:0] code);
      case (code)
         8'h01, 8'h02, 8'h03, 8'h04, 8'h08, 8'h0B, 8'h0D, 8'h0F: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic op_programs(input logic [7:0] code);
      return (code == 8'h01) || (code == 8'h03);
   endfunction

endpackage

// File: rtl/fwl_wait_gen.sv
module fwl_wait_gen #(
   parameter int FWS_W      = 2,
   parameter bit CAP_AT_MAX = 1'b1
) (
   input  logic [FWS_W-1:0] fws,
   output logic [FWS_W:0]   wait_n
);
   localparam logic [FWS_W:0] ONE = (FWS_W+1)'(1);

   logic [FWS_W:0] fws_ext;
   assign fws_ext = {1'b0, fws};

   if (FWS_W < 1) begin : g_bad_w
      $error("fwl_wait_gen: FWS_W must be at least 1");
   end

   if (CAP_AT_MAX) begin : g_cap
      // the largest setting writes in as many cycles as it reads
      always_comb begin
         if (fws == {FWS_W{1'b1}}) wait_n = fws_ext;
         else                      wait_n = fws_ext + ONE;
      end
   end else begin : g_plain
      assign wait_n = fws_ext + ONE;
   end
endmodule

// File: rtl/fwl_latch.sv
module fwl_latch #(
   parameter int IDX_W  = 6,
   parameter int DATA_W = 32,
   localparam int WORDS = 2 ** IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = mem[ridx];
endmodule

// File: rtl/fwl_cmd_seq.sv
module fwl_cmd_seq
   import fwl_pkg::*;
#(
   parameter int BUSY_CYCLES = 96,
   parameter int IDX_W       = 6,
   parameter int NUM_PAGES   = 16,
   parameter int NVM_BITS    = 2,
   localparam int PAGE_W     = $clog2(NUM_PAGES),
   localparam int NVM_IW     = $clog2(NVM_BITS),
   localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [7:0]           code,
   input  logic [PAGE_W-1:0]    page,
   output logic                 busy,
   output logic                 ready,
   output logic                 prog_we,
   output logic [IDX_W-1:0]     prog_idx,
   output logic                 latch_clr,
   output logic [NUM_PAGES-1:0] lock,
   output logic [NVM_BITS-1:0]  nvm,
   output logic                 secure
);
   localparam logic [IDX_W:0] WORDS_C = (IDX_W+1)'(2 ** IDX_W);
   localparam logic [CNT_W-1:0] BUSY_C = CNT_W'(BUSY_CYCLES);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0]  cnt;
   fwl_op_e           op_q;
   logic [PAGE_W-1:0] page_q;
   logic [IDX_W:0]    ptr;
   logic              prog_on;
   logic              last;

   assign last      = busy && (cnt == CNT_ONE);
   assign prog_we   = busy && prog_on && (ptr < WORDS_C);
   assign prog_idx  = ptr[IDX_W-1:0];
   assign latch_clr = last && op_programs(op_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         ready   <= 1'b1;
         cnt     <= '0;
         op_q    <= OP_ERASE_ALL;
         page_q  <= '0;
         ptr     <= '0;
         prog_on <= 1'b0;
         lock    <= '0;
         nvm     <= '0;
         secure  <= 1'b0;
      end else if (start) begin
         busy    <= 1'b1;
         ready   <= 1'b0;
         cnt     <= BUSY_C;
         op_q    <= fwl_op_e'(code);
         page_q  <= page;
         ptr     <= '0;
         prog_on <= op_programs(code);
      end else if (busy) begin
         cnt <= cnt - CNT_ONE;
         if (prog_we) ptr <= ptr + (IDX_W+1)'(1);
         if (last) begin
            busy    <= 1'b0;
            ready   <= 1'b1;
            prog_on <= 1'b0;
            case (op_q)
               OP_SET_LOCK,
               OP_WRITE_LOCK: lock[page_q] <= 1'b1;
               OP_CLR_LOCK:   lock[page_q] <= 1'b0;
               OP_SET_NVM:    nvm[page_q[NVM_IW-1:0]] <= 1'b1;
               OP_CLR_NVM:    nvm[page_q[NVM_IW-1:0]] <= 1'b0;
               OP_SET_SEC:    secure <= 1'b1;
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/flash_wlatch_unit.sv
module flash_wlatch_unit
   import fwl_pkg::*;
#(
   parameter int FWS_W       = 2,
   parameter bit CAP_AT_MAX  = 1'b1,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int LOW_BITS    = 8,
   parameter int NUM_PAGES   = 16,
   parameter int NVM_BITS    = 2,
   parameter int BUSY_CYCLES = 96,
   localparam int IDX_W      = LOW_BITS - 2,
   localparam int STRB_W     = DATA_W / 8,
   localparam int PAGE_W     = $clog2(NUM_PAGES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [FWS_W-1:0]     fws,
   input  logic                 bus_wr_valid,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [STRB_W-1:0]    bus_strb,
   input  logic                 bus_prot,
   output logic                 bus_wr_ready,
   output logic                 bus_wr_done,
   input  logic                 cmd_valid,
   input  logic [7:0]           cmd_code,
   input  logic [PAGE_W-1:0]    cmd_page,
   output logic                 st_busy,
   output logic                 st_ready,
   output logic                 st_cmd_err,
   output logic                 st_size_err,
   output logic                 st_prot_err,
   output logic                 st_busy_err,
   output logic [NUM_PAGES-1:0] st_lock,
   output logic [NVM_BITS-1:0]  st_nvm,
   output logic                 st_secure,
   output logic                 prog_we,
   output logic [IDX_W-1:0]     prog_idx,
   output logic [DATA_W-1:0]    prog_data
);
   // elaboration checks
   if (DATA_W != 32) begin : g_bad_data
      $error("flash_wlatch_unit: only full 32-bit words are supported");
   end
   if (LOW_BITS < 3 || LOW_BITS >= ADDR_W) begin : g_bad_low
      $error("flash_wlatch_unit: LOW_BITS out of range");
   end
   if (BUSY_CYCLES < (2 ** IDX_W) + 1) begin : g_bad_busy
      $error("flash_wlatch_unit: busy period shorter than one page stream");
   end
   if (NUM_PAGES < 2 || (NUM_PAGES & (NUM_PAGES - 1)) != 0) begin : g_bad_pages
      $error("flash_wlatch_unit: NUM_PAGES must be a power of two");
   end
   if (NVM_BITS < 2 || NVM_BITS > NUM_PAGES || (NVM_BITS & (NVM_BITS - 1)) != 0) begin : g_bad_nvm
      $error("flash_wlatch_unit: NVM_BITS must be a power of two within NUM_PAGES");
   end

   localparam logic [STRB_W-1:0] FULL_STRB = {STRB_W{1'b1}};
   localparam logic [FWS_W:0]    W_ONE     = (FWS_W+1)'(1);

   logic              unused_addr;
   assign unused_addr = ^{bus_addr[ADDR_W-1:LOW_BITS], bus_addr[1:0]};

   logic [FWS_W:0]    wait_n;
   logic              pend;
   logic [FWS_W:0]    pend_cnt;
   logic [IDX_W-1:0]  pend_idx;
   logic [DATA_W-1:0] pend_data;
   logic              latch_clr;

   logic wr_req, cmd_go, wr_accept;
   logic hit_size, hit_prot, hit_busy, hit_cmd;

   fwl_wait_gen #(.FWS_W(FWS_W), .CAP_AT_MAX(CAP_AT_MAX)) u_wait (
      .fws    (fws),
      .wait_n (wait_n)
   );

   // admission: a command start wins over a write in the same cycle
   assign wr_req    = bus_wr_valid && !pend;
   assign cmd_go    = cmd_valid && !st_busy && !pend && op_known(cmd_code);
   assign hit_size  = wr_req && !st_busy && !cmd_go && (bus_strb != FULL_STRB);
   assign hit_prot  = wr_req && !st_busy && !cmd_go && (bus_strb == FULL_STRB) && bus_prot;
   assign wr_accept = wr_req && !st_busy && !cmd_go && (bus_strb == FULL_STRB) && !bus_prot;
   assign hit_busy  = (wr_req && (st_busy || cmd_go)) || (cmd_valid && (st_busy || pend));
   assign hit_cmd   = cmd_valid && !st_busy && !pend && !op_known(cmd_code);

   assign bus_wr_ready = !pend;
   assign bus_wr_done  = pend && (pend_cnt == W_ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend      <= 1'b0;
         pend_cnt  <= '0;
         pend_idx  <= '0;
         pend_data <= '0;
      end else if (wr_accept) begin
         pend      <= 1'b1;
         pend_cnt  <= wait_n;
         pend_idx  <= bus_addr[LOW_BITS-1:2];
         pend_data <= bus_wdata;
      end else if (bus_wr_done) begin
         pend      <= 1'b0;
      end else if (pend) begin
         pend_cnt  <= pend_cnt - W_ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_cmd_err  <= 1'b0;
         st_size_err <= 1'b0;
         st_prot_err <= 1'b0;
         st_busy_err <= 1'b0;
      end else begin
         st_cmd_err  <= (st_cmd_err  && !cmd_go) || hit_cmd;
         st_size_err <= (st_size_err && !cmd_go) || hit_size;
         st_prot_err <= (st_prot_err && !cmd_go) || hit_prot;
         st_busy_err <= (st_busy_err && !cmd_go) || hit_busy;
      end
   end

   fwl_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr_done),
      .widx  (pend_idx),
      .wdata (pend_data),
      .clr   (latch_clr),
      .ridx  (prog_idx),
      .rdata (prog_data)
   );

   fwl_cmd_seq #(
      .BUSY_CYCLES (BUSY_CYCLES),
      .IDX_W       (IDX_W),
      .NUM_PAGES   (NUM_PAGES),
      .NVM_BITS    (NVM_BITS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cmd_go),
      .code      (cmd_code),
      .page      (cmd_page),
      .busy      (st_busy),
      .ready     (st_ready),
      .prog_we   (prog_we),
      .prog_idx  (prog_idx),
      .latch_clr (latch_clr),
      .lock      (st_lock),
      .nvm       (st_nvm),
      .secure    (st_secure)
   );
endmodule

// File: rtl/fwl_checker.sv
module fwl_checker
   import fwl_pkg::*;
#(
   parameter int FWS_W  = 2,
   parameter int STRB_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [FWS_W-1:0]  fws,
   input logic              bus_wr_valid,
   input logic [STRB_W-1:0] bus_strb,
   input logic              bus_wr_ready,
   input logic              bus_wr_done,
   input logic              cmd_valid,
   input logic [7:0]        cmd_code,
   input logic              st_busy,
   input logic              st_ready,
   input logic              st_cmd_err,
   input logic              st_size_err,
   input logic              st_busy_err,
   input logic              prog_we
);
   // R4: setting 0 finishes in the first cycle after acceptance
   a_r4_fws0_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_wr_ready) && fws == '0) |-> bus_wr_done);

   // R4: setting 1 finishes in the second cycle
   a_r4_fws1_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_wr_ready) && fws == FWS_W'(1)) |-> (!bus_wr_done ##1 bus_wr_done));

   // R2: a narrow write flags and never opens a wait period
   a_r2_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_valid && bus_wr_ready && !st_busy && !cmd_valid && bus_strb != {STRB_W{1'b1}})
      |=> (st_size_err && bus_wr_ready));

   // R5: program words only appear inside a busy period
   a_r5_prog_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      prog_we |-> st_busy);

   // R6: ready returns as busy ends
   a_r6_ready_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_busy) |-> st_ready);

   // R11: unknown code starts nothing
   a_r11_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !st_busy && bus_wr_ready && !op_known(cmd_code))
      |=> (!st_busy && st_cmd_err));

   // R12: command on top of a running one is flagged
   a_r12_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && st_busy) |=> st_busy_err);
endmodule

bind flash_wlatch_unit fwl_checker #(.FWS_W(FWS_W), .STRB_W(STRB_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fws          (fws),
   .bus_wr_valid (bus_wr_valid),
   .bus_strb     (bus_strb),
   .bus_wr_ready (bus_wr_ready),
   .bus_wr_done  (bus_wr_done),
   .cmd_valid    (cmd_valid),
   .cmd_code     (cmd_code),
   .st_busy      (st_busy),
   .st_ready     (st_ready),
   .st_cmd_err   (st_cmd_err),
   .st_size_err  (st_size_err),
   .st_busy_err  (st_busy_err),
   .prog_we      (prog_we)
);

// File: tb/flash_wlatch_unit_bench.sv
module flash_wlatch_unit_bench;
   localparam int NP    = 8;
   localparam int NB    = 2;
   localparam int BUSY  = 70;
   localparam int WORDS = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fws = '0;
   logic        bus_wr_valid = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_strb = '0;
   logic        bus_prot = 1'b0;
   logic        bus_wr_ready, bus_wr_done;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [2:0]  cmd_page = '0;
   logic        st_busy, st_ready, st_cmd_err, st_size_err, st_prot_err, st_busy_err;
   logic [NP-1:0] st_lock;
   logic [NB-1:0] st_nvm;
   logic        st_secure, prog_we;
   logic [5:0]  prog_idx;
   logic [31:0] prog_data;

   int checks = 0;
   int errors = 0;
   int prog_cnt = 0;

   typedef struct { logic [5:0] idx; logic [31:0] data; } sb_item_t;
   sb_item_t exp_q[$];
   sb_item_t cur;
   logic [31:0] model [WORDS];

   always #10 clk = ~clk;

   flash_wlatch_unit #(.NUM_PAGES(NP), .NVM_BITS(NB), .BUSY_CYCLES(BUSY)) u_flash_wlatch_unit (
      .clk(clk), .rst_n(rst_n), .fws(fws),
      .bus_wr_valid(bus_wr_valid), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_strb(bus_strb), .bus_prot(bus_prot),
      .bus_wr_ready(bus_wr_ready), .bus_wr_done(bus_wr_done),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_page(cmd_page),
      .st_busy(st_busy), .st_ready(st_ready), .st_cmd_err(st_cmd_err),
      .st_size_err(st_size_err), .st_prot_err(st_prot_err), .st_busy_err(st_busy_err),
      .st_lock(st_lock), .st_nvm(st_nvm), .st_secure(st_secure),
      .prog_we(prog_we), .prog_idx(prog_idx), .prog_data(prog_data)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected program words (R1, R5, R8)
   always @(negedge clk) begin
      if (rst_n && prog_we) begin
         prog_cnt++;
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R5: program word idx %0d data %0h actual, expected none", prog_idx, prog_data);
         end else begin
            cur = exp_q.pop_front();
            chk("R5 program index", 64'(prog_idx), 64'(cur.idx));
            chk("R1/R5 program data", 64'(prog_data), 64'(cur.data));
         end
      end
   end

   task automatic good_write(input logic [31:0] a, input logic [31:0] d, input int exp_lat, input string tag);
      int n;
      @(negedge clk);
      bus_wr_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = 4'hF; bus_prot = 1'b0;
      @(negedge clk);
      bus_wr_valid = 1'b0;
      n = 1;
      while (!bus_wr_done && n < 10) begin
         @(negedge clk);
         n++;
      end
      chk(tag, 64'(n), 64'(exp_lat));
      @(negedge clk);
      chk("R4 ready after done", 64'(bus_wr_ready), 64'd1);
      model[a[7:2]] = d;
   endtask

   task automatic bad_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input logic p);
      @(negedge clk);
      bus_wr_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_strb = s; bus_prot = p;
      @(negedge clk);
      bus_wr_valid = 1'b0; bus_prot = 1'b0;
      chk("R2/R3 no wait after reject", 64'(bus_wr_ready), 64'd1);
   endtask

   task automatic push_page();
      for (int i = 0; i < WORDS; i++) begin
         cur.idx = 6'(i);
         cur.data = model[i];
         exp_q.push_back(cur);
      end
   endtask

   task automatic run_cmd(input logic [7:0] c, input logic [2:0] pg);
      int n;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = c; cmd_page = pg;
      if (c == 8'h01 || c == 8'h03) push_page();
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R6 ready low while busy", 64'(st_ready), 64'd0);
      n = 0;
      while (st_busy && n < 500) begin
         n++;
         @(negedge clk);
      end
      chk("R6 busy length", 64'(n), 64'(BUSY));
      chk("R6 ready after busy", 64'(st_ready), 64'd1);
      if (c == 8'h01 || c == 8'h03) begin
         for (int i = 0; i < WORDS; i++) model[i] = '0;
         chk("R5 all words streamed", 64'(exp_q.size()), 64'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int pc;
      for (int i = 0; i < WORDS; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 / R6 reset state
      chk("R6 reset ready", 64'(st_ready), 64'd1);
      chk("R6 reset busy", 64'(st_busy), 64'd0);
      chk("R13 reset flags", 64'({st_cmd_err, st_size_err, st_prot_err, st_busy_err}), 64'd0);
      chk("R7 reset locks", 64'(st_lock), 64'd0);
      chk("R4 reset wr ready", 64'(bus_wr_ready), 64'd1);

      // R4 latency for every setting
      fws = 2'd0; good_write(32'h0000_0000, 32'hA000_0000, 1, "R4 latency fws0");
      fws = 2'd1; good_write(32'h0000_0008, 32'hA000_0002, 2, "R4 latency fws1");
      fws = 2'd2; good_write(32'h0000_00FC, 32'hA000_003F, 3, "R4 latency fws2");
      fws = 2'd3; good_write(32'h0000_0020, 32'hA000_0008, 3, "R4 latency fws3 capped");
      fws = 2'd1;

      // R1 aliasing: both land on word 1, the second one wins
      good_write(32'h0010_0104, 32'h1111_1111, 2, "R1 alias write a");
      good_write(32'h0020_0006, 32'h2222_2222, 2, "R1 alias write b");
      good_write(32'hFFFF_FF48, 32'h3333_3333, 2, "R1 high alias");

      // R2 narrow write
      bad_write(32'h0000_0014, 32'hDEAD_0014, 4'h3, 1'b0);
      chk("R2 size flag", 64'(st_size_err), 64'd1);
      // R3 protected write
      bad_write(32'h0000_0018, 32'hDEAD_0018, 4'hF, 1'b1);
      chk("R3 prot flag", 64'(st_prot_err), 64'd1);
      repeat (3) @(negedge clk);
      chk("R13 flags sticky", 64'({st_size_err, st_prot_err}), 64'd3);

      // R5 program page; the monitor verifies words 5/6 were not touched
      run_cmd(8'h01, 3'd0);
      chk("R13 flags cleared by command", 64'({st_size_err, st_prot_err}), 64'd0);
      // R5 latch empty after programming
      run_cmd(8'h01, 3'd0);

      // R7 lock bits
      run_cmd(8'h02, 3'd3);
      chk("R7 set lock 3", 64'(st_lock), 64'h08);
      run_cmd(8'h04, 3'd3);
      chk("R7 clear lock 3", 64'(st_lock), 64'h00);
      run_cmd(8'h02, 3'd5);
      chk("R7 set lock 5", 64'(st_lock), 64'h20);

      // R8 program and lock
      good_write(32'h0000_0030, 32'h0BAD_F00D, 2, "R8 setup write");
      run_cmd(8'h03, 3'd2);
      chk("R8 lock 2 set", 64'(st_lock), 64'h24);

      // R9 non-volatile bits and security
      run_cmd(8'h0B, 3'd1);
      chk("R9 nvm set 1", 64'(st_nvm), 64'h2);
      run_cmd(8'h0B, 3'd6);
      chk("R9 nvm set via folded page", 64'(st_nvm), 64'h3);
      run_cmd(8'h0D, 3'd1);
      chk("R9 nvm clear 1", 64'(st_nvm), 64'h1);
      run_cmd(8'h0F, 3'd0);
      chk("R9 secure", 64'(st_secure), 64'd1);

      // R10 erase all
      good_write(32'h0000_0040, 32'h4444_4444, 2, "R10 setup write");
      pc = prog_cnt;
      run_cmd(8'h08, 3'd0);
      chk("R10 no program words", 64'(prog_cnt - pc), 64'd0);
      chk("R10 state unchanged", 64'({st_lock, st_nvm, st_secure}), 64'({8'h24, 2'h1, 1'b1}));

      // R11 unknown code
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h05; cmd_page = 3'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 not busy", 64'(st_busy), 64'd0);
      chk("R11 cmd error", 64'(st_cmd_err), 64'd1);
      repeat (2) @(negedge clk);
      chk("R13 cmd error sticky", 64'(st_cmd_err), 64'd1);

      // R12 overlap: command and write during busy
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h02; cmd_page = 3'd0;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R13 cmd error cleared", 64'(st_cmd_err), 64'd0);
      repeat (5) @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h0B; cmd_page = 3'd1;
      @(negedge clk);
      cmd_valid = 1'b0;
      bus_wr_valid = 1'b1; bus_addr = 32'h0000_0050; bus_wdata = 32'h5555_5555; bus_strb = 4'hF;
      @(negedge clk);
      bus_wr_valid = 1'b0;
      chk("R12 busy flag", 64'(st_busy_err), 64'd1);
      chk("R12 write not started", 64'(bus_wr_ready), 64'd1);
      while (st_busy) @(negedge clk);
      chk("R12 running op completes", 64'(st_lock), 64'h25);
      chk("R12 overlapping op ignored", 64'(st_nvm), 64'h1);
      // latch still holds only the erase-setup word
      run_cmd(8'h01, 3'd0);

      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule